// File: doc/BRIEF.md
# Flash Sector Protection Engine

This block changes the write protection of one sector of a parallel NOR flash and then checks that the change took effect. A caller gives it a sector base word address and a flag that selects lock or unlock. The caller raises `start`, and the engine answers with a one-cycle `start_ack`. From then on the engine owns a generic word-wide flash bus. On that bus it first sends a reset write. Next it sends the protection command three times. The choice between lock and unlock is carried by word-address bit 6 of the target address, not by the data. The engine then enters the identification mode, reads the sector's protection status word and returns the flash to read mode.

When the sequence ends, the engine raises `done` for one cycle. In that same cycle `fail` and `prot_locked` are valid. `prot_locked` is the protection bit that was read back. `fail` is set when the state read back differs from the state that was asked for. A range that covers several sectors is handled by the caller, which issues one request per sector.

Each bus cycle on the flash bus is a request held until the flash side acknowledges it. The flash side can therefore stretch any cycle by any number of clocks.

Top module: `secprot_engine`

## Requirements
- R1: While `busy` is low, a cycle with `start` high is accepted. The engine captures `sec_addr` and `lock_req`, raises `start_ack` for exactly one cycle and raises `busy`. While `busy` is high, `start` is ignored: no `start_ack` is given, and the captured address and flag do not change.
- R2: The first bus cycle of every operation writes 0xF0 to the sector base address.
- R3: Bus cycles 2, 3 and 4 each write 0x60 to the protection address. This address is the sector base address with bit 6 forced to 1 for an unlock (`lock_req`=0) and forced to 0 for a lock (`lock_req`=1). All other address bits are the base address bits.
- R4: Bus cycles 5, 6 and 7 enter the identification mode. They write 0xAA to base+0x555, then 0x55 to base+0x2AA, then 0x90 to base+0x555.
- R5: Bus cycle 8 is a read of base+2. Only bit 0 of the word read is used (1 = locked, 0 = unlocked). Bits 15..1 have no effect on any output.
- R6: Bus cycle 9, the last one, writes 0xF0 to the sector base address.
- R7: At completion, `prot_locked` equals the bit read in R5. `fail` is 1 when an unlock left the sector locked or a lock left it unlocked, and 0 otherwise.
- R8: `done` is high for exactly one cycle per accepted request. `fail` and `prot_locked` are valid in that cycle, and `busy` is already low in that cycle.
- R9: Once `fb_req` rises, it stays high with `fb_we`, `fb_addr` and `fb_wdata` held steady until a cycle in which `fb_ack` is high. The engine then drops `fb_req`.
- R10: After reset, `busy`, `done`, `fail`, `prot_locked`, `start_ack` and `fb_req` are all 0. `fb_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to change one sector's protection |
| sec_addr | input | AW | Sector base word address |
| lock_req | input | 1 | 1 = lock the sector, 0 = unlock it |
| start_ack | output | 1 | One-cycle acknowledge of an accepted request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Requested protection state was not reached (valid with done) |
| prot_locked | output | 1 | Protection bit read back (valid with done) |
| fb_req | output | 1 | Flash bus cycle request |
| fb_we | output | 1 | 1 = write cycle, 0 = read cycle |
| fb_addr | output | AW | Flash word address |
| fb_wdata | output | DW | Flash write data |
| fb_ack | input | 1 | Flash side completes the current cycle |
| fb_rdata | input | DW | Read data, valid when fb_ack is high on a read |

## Verification
The assertions assume that the flash side raises `fb_ack` only while `fb_req` is high, and that it keeps `fb_ack` high for a single cycle at a time. The bench flash model meets this by registering its acknowledge. It acknowledges only when a request is pending and the acknowledge is not already high, and it waits a programmable latency first.

The assertions also assume that a request address is steady while `start` is high. The bench changes `start`, `sec_addr` and `lock_req` only on the falling clock edge and drops `start` as soon as it sees `start_ack`. The one exception is the busy-window test, which keeps `start` high on purpose but releases it well before the running operation ends.

// File: rtl/secprot_pkg.sv
package secprot_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;

  localparam logic [7:0] OP_READ_MODE = 8'hF0;
  localparam logic [7:0] OP_PROTECT   = 8'h60;
  localparam logic [7:0] OP_KEY_A     = 8'hAA;
  localparam logic [7:0] OP_KEY_B     = 8'h55;
  localparam logic [7:0] OP_ID_MODE   = 8'h90;

  localparam int KEY_A_OFS  = 'h555;
  localparam int KEY_B_OFS  = 'h2AA;
  localparam int STATUS_OFS = 2;
  localparam int SEL_BIT    = 6;

  localparam int NUM_STEPS  = 9;
  localparam int STEP_W     = $clog2(NUM_STEPS);

endpackage

// File: rtl/secprot_steps.sv
module secprot_steps
  import secprot_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     base,
  input  logic              unlock,
  output logic              cmd_we,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_wdata
);

  logic [AW-1:0] prot_addr;

  always_comb begin
    prot_addr          = base;
    prot_addr[SEL_BIT] = unlock;
  end

  always_comb begin
    cmd_we    = 1'b1;
    cmd_addr  = base;
    cmd_wdata = DW'(OP_READ_MODE);
    case (step)
      STEP_W'(0): begin
        cmd_addr  = base;
        cmd_wdata = DW'(OP_READ_MODE);
      end
      STEP_W'(1), STEP_W'(2), STEP_W'(3): begin
        cmd_addr  = prot_addr;
        cmd_wdata = DW'(OP_PROTECT);
      end
      STEP_W'(4): begin
        cmd_addr  = base + AW'(KEY_A_OFS);
        cmd_wdata = DW'(OP_KEY_A);
      end
      STEP_W'(5): begin
        cmd_addr  = base + AW'(KEY_B_OFS);
        cmd_wdata = DW'(OP_KEY_B);
      end
      STEP_W'(6): begin
        cmd_addr  = base + AW'(KEY_A_OFS);
        cmd_wdata = DW'(OP_ID_MODE);
      end
      STEP_W'(7): begin
        cmd_we    = 1'b0;
        cmd_addr  = base + AW'(STATUS_OFS);
        cmd_wdata = '0;
      end
      default: begin
        cmd_addr  = base;
        cmd_wdata = DW'(OP_READ_MODE);
      end
    endcase
  end

endmodule

// File: rtl/secprot_busif.sv
module secprot_busif #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          cyc_done,
  output logic          rd_bit,
  output logic          fb_req,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_wdata,
  input  logic          fb_ack,
  input  logic [DW-1:0] fb_rdata
);

  logic unused_rdata_hi;
  assign unused_rdata_hi = ^fb_rdata[DW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_req   <= 1'b0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
      cyc_done <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      if (go && !fb_req) begin
        fb_req   <= 1'b1;
        fb_we    <= go_we;
        fb_addr  <= go_addr;
        fb_wdata <= go_wdata;
      end else if (fb_req && fb_ack) begin
        fb_req   <= 1'b0;
        cyc_done <= 1'b1;
        if (!fb_we) rd_bit <= fb_rdata[0];
      end
    end
  end

endmodule

// File: rtl/secprot_ctrl.sv
module secprot_ctrl
  import secprot_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     sec_addr,
  input  logic              lock_req,
  input  logic              cyc_done,
  input  logic              rd_bit,
  output logic              go,
  output logic [STEP_W-1:0] step,
  output logic [AW-1:0]     base_q,
  output logic              unlock_q,
  output logic              start_ack,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              prot_locked
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_t state;

  assign go = (state == SQ_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      step        <= '0;
      base_q      <= '0;
      unlock_q    <= 1'b0;
      start_ack   <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      prot_locked <= 1'b0;
    end else begin
      start_ack <= 1'b0;
      done      <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            base_q    <= sec_addr;
            unlock_q  <= !lock_req;
            step      <= '0;
            start_ack <= 1'b1;
            busy      <= 1'b1;
            state     <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (cyc_done) begin
            if (step == LAST_STEP) begin
              done        <= 1'b1;
              busy        <= 1'b0;
              prot_locked <= rd_bit;
              fail        <= (rd_bit == unlock_q);
              state       <= SQ_IDLE;
            end else begin
              step  <= step + 1'b1;
              state <= SQ_ISSUE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/secprot_engine.sv
module secprot_engine
  import secprot_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] sec_addr,
  input  logic          lock_req,
  output logic          start_ack,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          prot_locked,
  output logic          fb_req,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_wdata,
  input  logic          fb_ack,
  input  logic [DW-1:0] fb_rdata
);

  logic              go;
  logic [STEP_W-1:0] step;
  logic [AW-1:0]     base_q;
  logic              unlock_q;
  logic              cyc_done;
  logic              rd_bit;
  logic              cmd_we;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     cmd_wdata;

  secprot_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .sec_addr(sec_addr),
    .lock_req(lock_req), .cyc_done(cyc_done), .rd_bit(rd_bit),
    .go(go), .step(step), .base_q(base_q), .unlock_q(unlock_q),
    .start_ack(start_ack), .busy(busy), .done(done), .fail(fail),
    .prot_locked(prot_locked)
  );

  secprot_steps #(.AW(AW), .DW(DW)) u_steps (
    .step(step), .base(base_q), .unlock(unlock_q),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
  );

  secprot_busif #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .go(go), .go_we(cmd_we), .go_addr(cmd_addr),
    .go_wdata(cmd_wdata), .cyc_done(cyc_done), .rd_bit(rd_bit),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_ack(fb_ack), .fb_rdata(fb_rdata)
  );

endmodule

// File: rtl/secprot_checker.sv
module secprot_checker #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_ack,
  input logic          busy,
  input logic          done,
  input logic          unlock_q,
  input logic          fb_req,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic [DW-1:0] fb_wdata,
  input logic          fb_ack
);

  assert_ack_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    start_ack |-> (busy && !$past(busy)));

  assert_prot_addr_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (fb_req && fb_we && fb_wdata == DW'(8'h60)) |-> (fb_addr[6] == unlock_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_cycle_held_R9: assert property (@(posedge clk) disable iff (rst)
    (fb_req && !fb_ack) |=> (fb_req && $stable(fb_addr) && $stable(fb_wdata) && $stable(fb_we)));

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fb_req);

endmodule

bind secprot_engine secprot_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start_ack(start_ack), .busy(busy), .done(done),
  .unlock_q(unlock_q), .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr),
  .fb_wdata(fb_wdata), .fb_ack(fb_ack)
);

// File: tb/sim_secprot_engine.sv
`timescale 1ns/1ps
module sim_secprot_engine;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] sec_addr = '0;
  logic          lock_req = 1'b0;
  logic          start_ack, busy, done, fail, prot_locked;
  logic          fb_req, fb_we;
  logic [AW-1:0] fb_addr;
  logic [DW-1:0] fb_wdata;
  logic          fb_ack = 1'b0;
  logic [DW-1:0] fb_rdata = '0;

  always #4 clk = ~clk;

  secprot_engine #(.AW(AW), .DW(DW)) u0 (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // flash model
  logic          sec_locked [0:7];
  logic          id_mode = 1'b0;
  int            prot_cnt = 0;
  logic [AW-1:0] prot_last = '0;
  int            latency = 0;
  int            wait_cnt = 0;
  logic          stuck = 1'b0;
  logic [DW-1:1] junk_hi = '0;
  logic [AW-1:0] log_addr [0:15];
  logic [DW-1:0] log_data [0:15];
  logic          log_we   [0:15];
  int            log_n = 0;
  int            ack_count = 0;

  function automatic int sec_of(logic [AW-1:0] a);
    return int'(a[17:15]);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (start_ack) ack_count <= ack_count + 1;
    if (fb_req && !fb_ack) begin
      if (wait_cnt >= latency) begin
        wait_cnt <= 0;
        fb_ack   <= 1'b1;
        if (log_n < 16) begin
          log_addr[log_n] <= fb_addr;
          log_data[log_n] <= fb_wdata;
          log_we[log_n]   <= fb_we;
        end
        log_n <= log_n + 1;
        if (fb_we) begin
          if (fb_wdata == 16'h00F0) begin
            id_mode <= 1'b0; prot_cnt <= 0;
          end else if (fb_wdata == 16'h0060) begin
            if (prot_cnt > 0 && prot_last == fb_addr && prot_cnt == 2) begin
              if (!stuck) sec_locked[sec_of(fb_addr)] <= !fb_addr[6];
              prot_cnt <= 0;
            end else if (prot_cnt > 0 && prot_last == fb_addr) prot_cnt <= prot_cnt + 1;
            else prot_cnt <= 1;
            prot_last <= fb_addr;
          end else if (fb_wdata == 16'h0090) id_mode <= 1'b1;
        end else begin
          if (id_mode && fb_addr[1:0] == 2'd2)
            fb_rdata <= {junk_hi, sec_locked[sec_of(fb_addr)]};
          else
            fb_rdata <= 16'hFFFF;
        end
      end else wait_cnt <= wait_cnt + 1;
    end else fb_ack <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic lk,
                        output logic f, output logic st);
    int t;
    @(negedge clk);
    log_n = 0;
    sec_addr = a; lock_req = lk; start = 1'b1;
    t = 0;
    while (!start_ack && t < 50) begin @(negedge clk); t++; end
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check("R8 done seen", {31'd0, done}, 32'd1);
    check("R8 busy low at done", {31'd0, busy}, 32'd0);
    f = fail; st = prot_locked;
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic check_log(input logic [AW-1:0] a, input logic unl);
    logic [AW-1:0] sla;
    logic [AW-1:0] ea [0:8];
    logic [15:0]   ed [0:8];
    sla = a; sla[6] = unl;
    ea[0] = a;          ed[0] = 16'h00F0;
    ea[1] = sla;        ed[1] = 16'h0060;
    ea[2] = sla;        ed[2] = 16'h0060;
    ea[3] = sla;        ed[3] = 16'h0060;
    ea[4] = a + 'h555;  ed[4] = 16'h00AA;
    ea[5] = a + 'h2AA;  ed[5] = 16'h0055;
    ea[6] = a + 'h555;  ed[6] = 16'h0090;
    ea[7] = a + 2;      ed[7] = 16'h0000;
    ea[8] = a;          ed[8] = 16'h00F0;
    check("R2 R6 cycle count", log_n, 9);
    check("R2 first addr", {10'd0, log_addr[0]}, {10'd0, ea[0]});
    check("R2 first data", {16'd0, log_data[0]}, {16'd0, ed[0]});
    for (int i = 1; i < 4; i++) begin
      check("R3 prot addr", {10'd0, log_addr[i]}, {10'd0, ea[i]});
      check("R3 prot data", {16'd0, log_data[i]}, {16'd0, ed[i]});
    end
    for (int i = 4; i < 7; i++) begin
      check("R4 id entry addr", {10'd0, log_addr[i]}, {10'd0, ea[i]});
      check("R4 id entry data", {16'd0, log_data[i]}, {16'd0, ed[i]});
    end
    check("R5 status read addr", {10'd0, log_addr[7]}, {10'd0, ea[7]});
    check("R5 status is read", {31'd0, log_we[7]}, 32'd0);
    check("R6 final addr", {10'd0, log_addr[8]}, {10'd0, ea[8]});
    check("R6 final data", {16'd0, log_data[8]}, {16'd0, ed[8]});
  endtask

  task automatic t_reset();
    check("R10 busy", {31'd0, busy}, 0);
    check("R10 done", {31'd0, done}, 0);
    check("R10 fail", {31'd0, fail}, 0);
    check("R10 prot_locked", {31'd0, prot_locked}, 0);
    check("R10 start_ack", {31'd0, start_ack}, 0);
    check("R10 fb_req", {31'd0, fb_req}, 0);
  endtask

  task automatic t_unlock();
    logic f, st;
    latency = 0; stuck = 0; junk_hi = '0;
    run_op(22'h018000, 1'b0, f, st);
    check_log(22'h018000, 1'b1);
    check("R7 unlock ok fail", {31'd0, f}, 0);
    check("R7 unlock state", {31'd0, st}, 0);
  endtask

  task automatic t_lock_slow();
    logic f, st;
    latency = 3; stuck = 0; junk_hi = '0;
    run_op(22'h028040, 1'b1, f, st);
    check_log(22'h028040, 1'b0);
    check("R7 R9 lock ok fail", {31'd0, f}, 0);
    check("R7 lock state", {31'd0, st}, 1);
  endtask

  task automatic t_stuck();
    logic f, st;
    latency = 1; stuck = 1;
    sec_locked[3] = 1'b1;
    run_op(22'h018000, 1'b0, f, st);
    check("R7 unlock stuck fail", {31'd0, f}, 1);
    check("R7 unlock stuck state", {31'd0, st}, 1);
    sec_locked[4] = 1'b0;
    run_op(22'h020000, 1'b1, f, st);
    check("R7 lock stuck fail", {31'd0, f}, 1);
    check("R7 lock stuck state", {31'd0, st}, 0);
    stuck = 0;
  endtask

  task automatic t_high_bits();
    logic f, st;
    latency = 0; junk_hi = '1;
    run_op(22'h038000, 1'b0, f, st);
    check("R5 upper bits ignored fail", {31'd0, f}, 0);
    check("R5 upper bits ignored state", {31'd0, st}, 0);
    junk_hi = '0;
  endtask

  task automatic t_busy_ignore();
    int acks0, t;
    latency = 2;
    acks0 = ack_count;
    @(negedge clk);
    log_n = 0;
    sec_addr = 22'h008000; lock_req = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    sec_addr = 22'h030000; lock_req = 1'b0; start = 1'b1;
    repeat (6) @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check("R1 one ack while busy", ack_count - acks0, 1);
    check("R1 lock result kept", {31'd0, prot_locked}, 1);
    @(negedge clk);
    check_log(22'h008000, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sec_locked[i] = (i == 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_lock_slow();
    t_stuck();
    t_high_bits();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule